// File: doc/BRIEF.md
# Victim-Aggressor Pattern Line Generator

This block builds the cache lines of crosstalk test patterns that a memory training engine later drives onto a data bus. Each of the 32 data lanes is cast as a victim, an aggressor, both or neither by two 32-bit masks. The lane's role selects an 8-beat code from a fixed four-entry table. The codes of all lanes are transposed so that chunk `c` of a line collects beat `c` of every lane. Each 32-bit chunk word is replicated into a 64-bit value.

A run starts with a one-cycle `start_i` pulse, which captures the two masks, a rotation count and a start line. For every rotation the block emits one line of eight chunks on a valid/ready write port, one chunk per accepted beat, tagged with its line address and chunk index. After each line it rotates both masks left by one lane. `busy_o` is high while a run is in progress, and `done_o` pulses once when the run ends. The storage that receives the lines lies outside this block.

Top module: `va_line_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `wr_valid_o` are 0, and `wr_valid_o` is never high while `busy_o` is low.
- R2: Each lane `b` takes its code from the table at index `{~victim[b], aggressor[b]}`. The table is index 0 = 8'hAA, index 1 = 8'hC0, index 2 = 8'hCC, index 3 = 8'hF0.
- R3: Bit `b` of the 32-bit word for chunk `c` (0..7) equals bit `c` of lane `b`'s code.
- R4: `wr_data_o[63:32]` and `wr_data_o[31:0]` both carry the 32-bit chunk word.
- R5: After the last chunk of a line is accepted, both captured masks rotate left by one bit, with bit 31 wrapping into bit 0, before the next line is built.
- R6: A run emits exactly as many lines as the rotation count. Line `v` carries address `(start + v) mod 2^ADDR_W`, and its chunks appear in index order 0 to 7.
- R7: While `wr_valid_o` is high and `wr_ready_i` is low, the line, chunk and data outputs hold. No chunk is dropped or repeated.
- R8: `done_o` is high for exactly one cycle, the cycle after the last chunk of the last line is accepted. In that cycle `busy_o` and `wr_valid_o` are low.
- R9: A start with a rotation count of 0 raises `done_o` in the next cycle and produces no valid beat.
- R10: Masks, count and start line are captured only by a start taken while idle. Changes on these inputs, or further start pulses while busy, do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| agg_mask_i | input | LANES (32) | Aggressor lane mask |
| vic_mask_i | input | LANES (32) | Victim lane mask |
| rot_cnt_i | input | ROT_W (8) | Number of lines to produce |
| start_line_i | input | ADDR_W (12) | Address of the first line |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| wr_valid_o | output | 1 | Chunk beat valid |
| wr_ready_i | input | 1 | Sink accepts the beat |
| wr_line_o | output | ADDR_W (12) | Line address of the beat |
| wr_chunk_o | output | 3 | Chunk index within the line |
| wr_data_o | output | LANES*REPL (64) | Replicated chunk data |

## Verification
A start pulse seen at one rising edge makes the first beat valid in the next cycle. A rotation count of 0 instead raises `done_o` in that cycle. The beat data is decoded combinationally from registered masks and the chunk counter, so each beat is compared in the cycle in which it is presented, and it moves on only at an edge where `wr_ready_i` was high. `done_o` is due exactly one cycle after the final accepted beat and must be gone one cycle later. The bench drives inputs just after the falling edge and samples one time unit later, and its reference model advances only on the beats it saw accepted.

// File: rtl/va_pkg.sv
package va_pkg;
   localparam int CODE_W  = 8;
   localparam int CHUNK_W = $clog2(CODE_W);

   // Role code of one lane, selected by {~victim, aggressor}
   function automatic logic [CODE_W-1:0] role_code(input logic vic, input logic agg);
      logic [CODE_W-1:0] c;
      case ({~vic, agg})
         2'd0:    c = 8'hAA;
         2'd1:    c = 8'hC0;
         2'd2:    c = 8'hCC;
         default: c = 8'hF0;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/va_lane_coder.sv
module va_lane_coder #(
   parameter int LANES = 32
) (
   input  logic [LANES-1:0]                    vic_i,
   input  logic [LANES-1:0]                    agg_i,
   output logic [LANES-1:0][va_pkg::CODE_W-1:0] code_o
);
   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign code_o[b] = va_pkg::role_code(vic_i[b], agg_i[b]);
   end
endmodule

// File: rtl/va_chunk_xpose.sv
module va_chunk_xpose #(
   parameter int LANES = 32,
   parameter int REPL  = 2
) (
   input  logic [LANES-1:0][va_pkg::CODE_W-1:0] code_i,
   input  logic [va_pkg::CHUNK_W-1:0]           chunk_i,
   output logic [LANES*REPL-1:0]                data_o
);
   logic [LANES-1:0] word;

   for (genvar b = 0; b < LANES; b++) begin : g_bit
      assign word[b] = code_i[b][chunk_i];
   end

   if (REPL == 1) begin : g_single
      assign data_o = word;
   end else begin : g_repl
      for (genvar r = 0; r < REPL; r++) begin : g_copy
         assign data_o[r*LANES +: LANES] = word;
      end
   end
endmodule

// File: rtl/va_seq_ctrl.sv
module va_seq_ctrl #(
   parameter int ADDR_W = 12,
   parameter int ROT_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [ROT_W-1:0]           rot_cnt_i,
   input  logic [ADDR_W-1:0]          start_line_i,
   input  logic                       ready_i,
   output logic                       busy_o,
   output logic                       done_o,
   output logic [ADDR_W-1:0]          line_o,
   output logic [va_pkg::CHUNK_W-1:0] chunk_o,
   output logic                       capture_o,
   output logic                       rotate_o
);
   logic [ROT_W-1:0] left_q;
   logic             accept, last_chunk;

   assign accept     = busy_o & ready_i;
   assign last_chunk = &chunk_o;
   assign capture_o  = ~busy_o & start_i;
   assign rotate_o   = accept & last_chunk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
         line_o  <= '0;
         chunk_o <= '0;
         left_q  <= '0;
      end else begin
         done_o <= 1'b0;
         if (capture_o) begin
            line_o  <= start_line_i;
            chunk_o <= '0;
            left_q  <= rot_cnt_i;
            if (rot_cnt_i == '0) done_o <= 1'b1;
            else                 busy_o <= 1'b1;
         end else if (accept) begin
            if (last_chunk) begin
               chunk_o <= '0;
               line_o  <= line_o + 1'b1;
               left_q  <= left_q - 1'b1;
               if (left_q == ROT_W'(1)) begin
                  busy_o <= 1'b0;
                  done_o <= 1'b1;
               end
            end else begin
               chunk_o <= chunk_o + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/va_line_gen.sv
module va_line_gen #(
   parameter int LANES  = 32,
   parameter int REPL   = 2,
   parameter int ADDR_W = 12,
   parameter int ROT_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [LANES-1:0]           agg_mask_i,
   input  logic [LANES-1:0]           vic_mask_i,
   input  logic [ROT_W-1:0]           rot_cnt_i,
   input  logic [ADDR_W-1:0]          start_line_i,
   output logic                       busy_o,
   output logic                       done_o,
   output logic                       wr_valid_o,
   input  logic                       wr_ready_i,
   output logic [ADDR_W-1:0]          wr_line_o,
   output logic [va_pkg::CHUNK_W-1:0] wr_chunk_o,
   output logic [LANES*REPL-1:0]      wr_data_o
);
   localparam int DATA_W = LANES * REPL;

   if (LANES < 2)  begin : g_bad_lanes $error("LANES must be at least 2"); end
   if (REPL < 1)   begin : g_bad_repl  $error("REPL must be at least 1"); end
   if (ADDR_W < 1) begin : g_bad_addr  $error("ADDR_W must be at least 1"); end
   if (ROT_W < 1)  begin : g_bad_rot   $error("ROT_W must be at least 1"); end

   logic [LANES-1:0]                    agg_q, vic_q;
   logic [LANES-1:0][va_pkg::CODE_W-1:0] codes;
   logic                                capture, rotate;

   va_seq_ctrl #(.ADDR_W(ADDR_W), .ROT_W(ROT_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .rot_cnt_i   (rot_cnt_i),
      .start_line_i(start_line_i),
      .ready_i     (wr_ready_i),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .line_o      (wr_line_o),
      .chunk_o     (wr_chunk_o),
      .capture_o   (capture),
      .rotate_o    (rotate)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         agg_q <= '0;
         vic_q <= '0;
      end else if (capture) begin
         agg_q <= agg_mask_i;
         vic_q <= vic_mask_i;
      end else if (rotate) begin
         agg_q <= {agg_q[LANES-2:0], agg_q[LANES-1]};
         vic_q <= {vic_q[LANES-2:0], vic_q[LANES-1]};
      end
   end

   va_lane_coder #(.LANES(LANES)) u_coder (
      .vic_i (vic_q),
      .agg_i (agg_q),
      .code_o(codes)
   );

   va_chunk_xpose #(.LANES(LANES), .REPL(REPL)) u_xpose (
      .code_i (codes),
      .chunk_i(wr_chunk_o),
      .data_o (wr_data_o)
   );

   assign wr_valid_o = busy_o;

   logic [DATA_W-1:0] unused_width_ref;
   assign unused_width_ref = wr_data_o;
endmodule

// File: rtl/va_line_gen_chk.sv
module va_line_gen_chk #(
   parameter int ADDR_W = 12,
   parameter int ROT_W  = 8,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ROT_W-1:0]  rot_cnt_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              wr_valid_o,
   input logic              wr_ready_i,
   input logic [ADDR_W-1:0] wr_line_o,
   input logic [2:0]        wr_chunk_o,
   input logic [DATA_W-1:0] wr_data_o
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !wr_valid_o);

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_data_o)
                                    && $stable(wr_line_o) && $stable(wr_chunk_o));

   // R6
   chunk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && wr_ready_i && (wr_chunk_o != 3'd7) |=>
         wr_valid_o && (wr_chunk_o == 3'($past(wr_chunk_o) + 3'd1)) && $stable(wr_line_o));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && !wr_valid_o);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> !done_o);

   // R9
   zero_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && (rot_cnt_i == '0) |=> done_o && !wr_valid_o);
endmodule

bind va_line_gen va_line_gen_chk #(.ADDR_W(ADDR_W), .ROT_W(ROT_W), .DATA_W(LANES*REPL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .rot_cnt_i (rot_cnt_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .wr_valid_o(wr_valid_o),
   .wr_ready_i(wr_ready_i),
   .wr_line_o (wr_line_o),
   .wr_chunk_o(wr_chunk_o),
   .wr_data_o (wr_data_o)
);

// File: tb/test_va_line_gen.sv
module test_va_line_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] agg_mask_i = '0, vic_mask_i = '0;
   logic [7:0]  rot_cnt_i = '0;
   logic [11:0] start_line_i = '0;
   logic        busy_o, done_o, wr_valid_o;
   logic        wr_ready_i = 1'b0;
   logic [11:0] wr_line_o;
   logic [2:0]  wr_chunk_o;
   logic [63:0] wr_data_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   va_line_gen i_va_line_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .agg_mask_i(agg_mask_i), .vic_mask_i(vic_mask_i),
      .rot_cnt_i(rot_cnt_i), .start_line_i(start_line_i),
      .busy_o(busy_o), .done_o(done_o), .wr_valid_o(wr_valid_o),
      .wr_ready_i(wr_ready_i), .wr_line_o(wr_line_o),
      .wr_chunk_o(wr_chunk_o), .wr_data_o(wr_data_o)
   );

   function automatic logic [7:0] tbl(input logic v, input logic a);
      // R2 table: victim only AA, both C0, neither CC, aggressor only F0
      if (v && !a) return 8'hAA;
      if (v && a)  return 8'hC0;
      if (!v && !a) return 8'hCC;
      return 8'hF0;
   endfunction

   function automatic logic [31:0] exp_word(input logic [31:0] a, input logic [31:0] v,
                                            input int c);
      logic [31:0] w;
      for (int b = 0; b < 32; b++) w[b] = tbl(v[b], a[b]) >> c;
      return w;
   endfunction

   function automatic logic [31:0] rol(input logic [31:0] x);
      return {x[30:0], x[31]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // One run: pct = ready probability, perturb = disturb inputs while busy (R10)
   task automatic run_fill(input logic [31:0] agg, input logic [31:0] vic,
                           input logic [7:0] rot, input logic [11:0] sl,
                           input int pct, input bit perturb);
      logic [31:0] ea = agg, ev = vic;
      int line = 0, ch = 0, guard = 0;
      string tag = perturb ? "R10" : "R2 R3 R5";
      @(negedge clk);
      start_i = 1'b1; agg_mask_i = agg; vic_mask_i = vic;
      rot_cnt_i = rot; start_line_i = sl;
      @(negedge clk);
      start_i = 1'b0;
      if (rot == 0) begin
         #1;
         chk(done_o === 1'b1 && wr_valid_o === 1'b0, "R9 done without beats",
             {62'd0, done_o, wr_valid_o}, 64'd2);
         @(negedge clk); #1;
         chk(done_o === 1'b0, "R8 done single cycle", {63'd0, done_o}, 64'd0);
         return;
      end
      while (line < rot && guard < 20000) begin
         guard++;
         wr_ready_i = (($urandom % 100) < pct);
         if (perturb) begin
            agg_mask_i = $urandom; vic_mask_i = $urandom;
            rot_cnt_i = $urandom; start_line_i = $urandom;
            start_i = !(line == rot - 1 && ch == 7) && ($urandom % 4 == 0);
         end
         #1;
         chk(wr_valid_o === 1'b1, "R6 beat valid", {63'd0, wr_valid_o}, 64'd1);
         chk(wr_line_o === 12'(sl + line), "R6 line address", 64'(wr_line_o), 64'(12'(sl + line)));
         chk(wr_chunk_o === 3'(ch), "R6 chunk order", 64'(wr_chunk_o), 64'(ch));
         chk(wr_data_o[31:0] === exp_word(ea, ev, ch), tag,
             wr_data_o, {32'd0, exp_word(ea, ev, ch)});
         chk(wr_data_o[63:32] === wr_data_o[31:0], "R4 replication",
             wr_data_o, {wr_data_o[31:0], wr_data_o[31:0]});
         if (!wr_ready_i)
            chk(busy_o === 1'b1, "R7 stall keeps run", {63'd0, busy_o}, 64'd1);
         if (wr_ready_i) begin
            if (ch == 7) begin
               ch = 0; line++; ea = rol(ea); ev = rol(ev);
            end else ch++;
         end
         @(negedge clk);
      end
      start_i = 1'b0; wr_ready_i = 1'b0;
      #1;
      chk(done_o === 1'b1 && busy_o === 1'b0 && wr_valid_o === 1'b0, "R8 done after last beat",
          {61'd0, done_o, busy_o, wr_valid_o}, 64'd4);
      @(negedge clk); #1;
      chk(done_o === 1'b0, "R8 done single cycle", {63'd0, done_o}, 64'd0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
         end
      end
   end

   initial begin
      logic [31:0] am [9] = '{32'h86186186, 32'h18618618, 32'h30c30c30,
                              32'ha28a28a2, 32'h8a28a28a, 32'h14514514,
                              32'h28a28a28, 32'h92492492, 32'h24924924};
      void'($urandom(32'd7531));
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(busy_o === 1'b0 && done_o === 1'b0 && wr_valid_o === 1'b0, "R1 reset state",
          {61'd0, busy_o, done_o, wr_valid_o}, 64'd0);
      rst_n = 1'b1;
      // basic fill, always ready
      run_fill(32'h0, 32'h01010101, 8'd8, 12'd0, 100, 1'b0);
      // nine three-role fills with back-pressure
      for (int k = 0; k < 9; k++)
         run_fill(am[k], 32'h41041041, 8'd6, 12'(8 + 6 * k), 60, 1'b0);
      // R9 zero count
      run_fill(32'hFFFF0000, 32'h0000FFFF, 8'd0, 12'd5, 100, 1'b0);
      // single line, heavy stall (R7)
      run_fill(32'h80000001, 32'h80000000, 8'd1, 12'd100, 20, 1'b0);
      // address wrap (R6)
      run_fill(32'h12345678, 32'h9ABCDEF0, 8'd4, 12'hFFE, 80, 1'b0);
      // mask wrap over many rotations (R5)
      run_fill(32'h00000001, 32'h80000000, 8'd40, 12'd200, 90, 1'b0);
      // random runs, inputs disturbed while busy (R10)
      for (int n = 0; n < 12; n++)
         run_fill($urandom, $urandom, 8'(1 + $urandom % 20), 12'($urandom), 50 + n * 4, 1'b1);
      finish_run();
   end
endmodule